// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block joins two 8-bit buses, called A and B, and moves data between them in either direction. Each side owns a storage register with its own clock: the A-side register samples the A bus, the B-side register samples the B bus. In each direction, a select input picks the outgoing data from one of two sources:
- the live value on the opposite bus, or
- the value held in that bus's register.

The chosen word is inverted bit by bit before it leaves the block.

An active-low output enable and a direction input decide which bus, if either, the block drives. Pads are modelled as separate input, output and output-enable vectors per bus, so the pad cells stay outside the block. The two registers keep sampling on their clock edges whether or not any output is enabled. A word can therefore be captured from a bus while another agent drives it. Both registers clear on an active-low asynchronous reset.

Top module: `reg_bus_xcvr`

## Requirements
- R1: On each rising edge of `clk_a_i`, the A-side register takes the value of `a_i`.
- R2: On each rising edge of `clk_b_i`, the B-side register takes the value of `b_i`.
- R3: Loading either register leaves the other register's contents unchanged.
- R4: The B output is `b_o = ~a_i` when `sel_a2b_i` is 0 (live source). It is `b_o = ~A-register` when `sel_a2b_i` is 1 (held source).
- R5: The A output is `a_o = ~b_i` when `sel_b2a_i` is 0 (live source). It is `a_o = ~B-register` when `sel_b2a_i` is 1 (held source).
- R6: While `oe_ni` is 1, both `a_oe_o` and `b_oe_o` are all zeros.
- R7: While `oe_ni` is 0, `dir_i` = 1 sets `b_oe_o` to all ones and `a_oe_o` to zeros. `dir_i` = 0 sets `a_oe_o` to all ones and `b_oe_o` to zeros.
- R8: Both registers load on their clock edges even while both output enables are deasserted.
- R9: While `rst_ni` is 0, both registers read zero at once, without waiting for a clock edge.
- R10: A change on `sel_a2b_i`, `sel_b2a_i`, `dir_i` or `oe_ni` reaches the outputs combinationally, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_a_i | input | 1 | Clock of the A-side register |
| clk_b_i | input | 1 | Clock of the B-side register |
| rst_ni | input | 1 | Active-low asynchronous reset of both registers |
| sel_a2b_i | input | 1 | Source for B outputs: 0 live A bus, 1 held A register |
| sel_b2a_i | input | 1 | Source for A outputs: 0 live B bus, 1 held B register |
| dir_i | input | 1 | 1 drives B bus, 0 drives A bus |
| oe_ni | input | 1 | Active-low output enable |
| a_i | input | 8 | A bus pad input |
| a_o | output | 8 | A bus pad output data |
| a_oe_o | output | 8 | A bus pad output enables |
| b_i | input | 8 | B bus pad input |
| b_o | output | 8 | B bus pad output data |
| b_oe_o | output | 8 | B bus pad output enables |

## Verification
Timing differs by path:
- Select, enable and live-data paths settle in the same cycle as their stimulus.
- A held value appears after the first rising edge of its register clock following the load request.
- Reset clears the registers immediately.

The bench changes inputs only while the clocks are low. It compares every output against a behavioural model twice in each cycle:
- once just after the falling edge, before new inputs are applied, which observes the previous rising edge's loads;
- once a moment after the new inputs are applied, with no clock edge in between, which observes the combinational paths.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  typedef enum logic {
    SRC_LIVE = 1'b0,
    SRC_HELD = 1'b1
  } src_sel_e;
endpackage

// File: rtl/xcvr_capture_reg.sv
module xcvr_capture_reg #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= d_i;
  end

  // R1 / R2: the value seen after an edge is the bus word sampled at it
  assert_capture_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) |-> q_o == $past(d_i));
endmodule

// File: rtl/xcvr_path_mux.sv
module xcvr_path_mux
  import xcvr_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         sel_i,
  input  logic [W-1:0] live_i,
  input  logic [W-1:0] held_i,
  output logic [W-1:0] out_o
);
  src_sel_e      src;
  logic [W-1:0]  pick;

  assign src = src_sel_e'(sel_i);

  always_comb begin
    unique case (src)
      SRC_HELD: pick = held_i;
      default:  pick = live_i;
    endcase
  end

  // inverting output stage
  assign out_o = ~pick;
endmodule

// File: rtl/xcvr_oe_ctrl.sv
module xcvr_oe_ctrl #(
  parameter int unsigned W = 8
) (
  input  logic         oe_ni,
  input  logic         dir_i,
  output logic [W-1:0] a_oe_o,
  output logic [W-1:0] b_oe_o
);
  logic drive_a, drive_b;

  assign drive_b = ~oe_ni & dir_i;
  assign drive_a = ~oe_ni & ~dir_i;

  for (genvar i = 0; i < W; i++) begin : g_pad
    assign a_oe_o[i] = drive_a;
    assign b_oe_o[i] = drive_b;
  end

  always_comb begin
    // R7: never both buses at once
    assert_one_side_R7: assert (!((|a_oe_o) && (|b_oe_o)));
    // R6: disabled means no pad enabled
    if (oe_ni) assert_all_off_R6: assert (a_oe_o == '0 && b_oe_o == '0);
  end
endmodule

// File: rtl/reg_bus_xcvr.sv
module reg_bus_xcvr #(
  parameter int unsigned W = 8
) (
  input  logic         clk_a_i,
  input  logic         clk_b_i,
  input  logic         rst_ni,
  input  logic         sel_a2b_i,
  input  logic         sel_b2a_i,
  input  logic         dir_i,
  input  logic         oe_ni,
  input  logic [W-1:0] a_i,
  output logic [W-1:0] a_o,
  output logic [W-1:0] a_oe_o,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] b_o,
  output logic [W-1:0] b_oe_o
);
  logic [W-1:0] held_a, held_b;

  xcvr_capture_reg #(.W(W)) u_reg_a (
    .clk_i(clk_a_i), .rst_ni(rst_ni), .d_i(a_i), .q_o(held_a)
  );

  xcvr_capture_reg #(.W(W)) u_reg_b (
    .clk_i(clk_b_i), .rst_ni(rst_ni), .d_i(b_i), .q_o(held_b)
  );

  xcvr_path_mux #(.W(W)) u_mux_a2b (
    .sel_i(sel_a2b_i), .live_i(a_i), .held_i(held_a), .out_o(b_o)
  );

  xcvr_path_mux #(.W(W)) u_mux_b2a (
    .sel_i(sel_b2a_i), .live_i(b_i), .held_i(held_b), .out_o(a_o)
  );

  xcvr_oe_ctrl #(.W(W)) u_oe (
    .oe_ni(oe_ni), .dir_i(dir_i), .a_oe_o(a_oe_o), .b_oe_o(b_oe_o)
  );

  // R4 / R5: live selection passes the opposite bus inverted
  always_comb begin
    if (!sel_a2b_i) assert_live_a2b_R4: assert ((b_o & a_i) == '0 && (b_o | a_i) == '1);
    if (!sel_b2a_i) assert_live_b2a_R5: assert ((a_o & b_i) == '0 && (a_o | b_i) == '1);
  end
endmodule

// File: tb/reg_bus_xcvr_test.sv
module reg_bus_xcvr_test;
  localparam int W = 8;
  localparam time CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic ld_a = 1'b0, ld_b = 1'b0;
  logic rst_n = 1'b0;
  logic sab = 1'b0, sba = 1'b0, dir = 1'b0, oe_n = 1'b1;
  logic [W-1:0] a_in = '0, b_in = '0;
  logic [W-1:0] a_out, a_oe, b_out, b_oe;
  int n_run = 0, n_fail = 0;
  bit done = 1'b0;
  string tag = "R9";

  // gated clocks; enables change only while clk is low
  wire clk_a = clk & ld_a;
  wire clk_b = clk & ld_b;

  always #(CLK_PERIOD / 2) clk = ~clk;

  reg_bus_xcvr #(.W(W)) uut (
    .clk_a_i(clk_a), .clk_b_i(clk_b), .rst_ni(rst_n),
    .sel_a2b_i(sab), .sel_b2a_i(sba), .dir_i(dir), .oe_ni(oe_n),
    .a_i(a_in), .a_o(a_out), .a_oe_o(a_oe),
    .b_i(b_in), .b_o(b_out), .b_oe_o(b_oe)
  );

  // behavioural reference state
  logic [W-1:0] m_a = '0, m_b = '0;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_a <= '0;
      m_b <= '0;
    end else begin
      if (ld_a) m_a <= a_in;
      if (ld_b) m_b <= b_in;
    end
  end

  task automatic chk(string what, logic [W-1:0] act, logic [W-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic compare_all();
    logic [W-1:0] e_b, e_a, e_boe, e_aoe;
    e_b   = ~(sab ? m_a : a_in);     // R4
    e_a   = ~(sba ? m_b : b_in);     // R5
    e_boe = (!oe_n && dir)  ? '1 : '0; // R6 R7
    e_aoe = (!oe_n && !dir) ? '1 : '0;
    chk("b_o", b_out, e_b);
    chk("a_o", a_out, e_a);
    chk("b_oe_o", b_oe, e_boe);
    chk("a_oe_o", a_oe, e_aoe);
  endtask

  // one cycle: check registered results, apply new inputs, check combinational results
  task automatic step(string t, logic [W-1:0] av, logic [W-1:0] bv, logic la, logic lb,
                      logic s_ab, logic s_ba, logic d, logic oen);
    @(negedge clk);
    #1 compare_all();
    tag = t;
    a_in = av; b_in = bv; ld_a = la; ld_b = lb;
    sab = s_ab; sba = s_ba; dir = d; oe_n = oen;
    #1 compare_all();
  endtask

  initial begin
    // R9: reset state
    repeat (2) step("R9", 8'h5a, 8'hc3, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1);
    @(negedge clk);
    rst_n = 1'b1;
    // R4 R5: live paths, several patterns
    for (int i = 0; i < 6; i++)
      step("R4", W'($urandom), W'($urandom), 1'b0, 1'b0, 1'b0, 1'b0, i[0], 1'b0);
    step("R5", 8'h00, 8'hff, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    // R1: load A, then read it back held while bus A changes
    step("R1", 8'h3c, 8'h00, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0);
    step("R1", 8'hf0, 8'h11, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0);
    step("R1", 8'h0f, 8'h22, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0);
    // R2: load B
    step("R2", 8'h00, 8'ha5, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0);
    step("R2", 8'h44, 8'h5a, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
    // R3: load only one side, other stays
    step("R3", 8'h99, 8'h66, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
    step("R3", 8'h12, 8'h34, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0);
    step("R3", 8'h00, 8'h00, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0);
    // R8: load with outputs disabled
    step("R8", 8'h81, 8'h7e, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1);
    step("R8", 8'h00, 8'h00, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1);
    // R6 R7: all enable combinations
    step("R6", 8'h01, 8'h02, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1);
    step("R7", 8'h03, 8'h04, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0);
    step("R7", 8'h05, 8'h06, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
    // R10: selects and enables toggle with no clock edge between
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      tag = "R10";
      sab = i[0]; sba = i[1]; dir = i[2]; oe_n = ~i[0];
      #1 compare_all();
      sab = ~sab; sba = ~sba; dir = ~dir; oe_n = ~oe_n;
      #1 compare_all();
    end
    // random mix
    for (int i = 0; i < 40; i++)
      step("R4", W'($urandom), W'($urandom), 1'($urandom), 1'($urandom),
           1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
    // R9: asynchronous clear mid-run, checked before any clock edge
    step("R9", 8'hee, 8'hdd, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0);
    @(negedge clk);
    #1 compare_all();
    ld_a = 1'b0; ld_b = 1'b0;
    #1 rst_n = 1'b0;
    tag = "R9";
    #1 compare_all();
    chk("held A cleared via b_o", b_out, 8'hff);
    rst_n = 1'b1;
    step("R9", 8'h00, 8'h00, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
    step("R9", 8'h00, 8'h00, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule